// File: doc/BRIEF.md
# Four-Voice Wavetable Oscillator

This block generates one stereo sample per sample tick by stepping four table-lookup oscillators and averaging what they read. Each voice owns a 32-bit phase register and a 32-bit increment register. Both hold a 9.15 fixed-point value in their low 24 bits, and both are reached byte by byte through a small register port. When a tick arrives and the run mode is selected, the voices advance one after another. For each voice the block issues one read to an external sample memory. It then averages the four unsigned bytes that come back and presents the result on both the left and right outputs, with a one-cycle valid strobe.

The sample memory holds 1024 bytes and answers one cycle after a read is issued. It is split into two 512-byte banks. Voices 0 and 1 share the lower bank and voices 2 and 3 share the upper bank. The memory's write side is owned by the surrounding system and is not part of this block.

Top module: `quad_wave_synth`

## Requirements
- R1: After reset every phase and increment register reads 0, the mode register reads 0, `sampleValid` is 0 and both audio outputs are 0.
- R2: Voice n has its phase register at byte address 0x10+8n and its increment register at 0x14+8n. Each register is 4 bytes, big-endian: the lowest address holds bits [31:24]. All 32 bits can be written and read back, and reads are combinational from `regAddr`.
- R3: The mode register is at address 0x01 and holds 2 bits. A write stores `regWrData[1:0]`, and the upper 6 bits read as 0.
- R4: On a tick that is accepted, each voice's phase becomes phase + increment modulo 2^32. The new value is visible through the register port after the sequence.
- R5: The read address for voice n is {bank, offset}. The offset is bits [23:15] of the voice's updated phase. The bank is address bit 9, which is 0 for voices 0–1 and 1 for voices 2–3.
- R6: An accepted tick on clock edge E0 produces exactly four reads, with `memRdEn` high in the cycles after edges E0, E1, E2 and E3. The reads go to voices 0, 1, 2, 3 in that order.
- R7: After edge E5, `leftOut` and `rightOut` both equal (s0+s1+s2+s3) >> 2, where sn is the byte returned for voice n. `sampleValid` is high for exactly that one cycle, and both outputs hold their value until the next result.
- R8: A tick is ignored while the mode register is not 2 (values 0, 1 and 3). No read is issued, no valid strobe appears and no phase changes.
- R9: A tick that arrives while a four-read sequence is in progress (edges E1 to E4) is ignored. Each voice still advances only once.
- R10: Phase bits [31:24] are kept and receive the carry out of bit 23, but they have no effect on the read address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample tick request |
| regAddr | input | 6 | Register byte address, for both read and write |
| regWrEn | input | 1 | Register byte write enable |
| regWrData | input | 8 | Register write byte |
| regRdData | output | 8 | Register read byte (combinational) |
| memRdEn | output | 1 | Sample memory read strobe |
| memRdAddr | output | 10 | Sample memory address {bank, offset} |
| memRdData | input | 8 | Sample memory data, returned one cycle after the read |
| leftOut | output | 8 | Left mixed sample |
| rightOut | output | 8 | Right mixed sample |
| sampleValid | output | 1 | One-cycle strobe marking a new stereo sample |

## Verification
A register read returns its data in the same cycle, so the bench samples it 1 ns after setting the address. An accepted tick on edge E0 produces its reads in the four cycles that follow. The bench logs each read with its cycle number and compares it with the expected cycle E0+1+k for voice k. The averaged byte and its strobe are due right after edge E5. The bench therefore samples on falling edges: `sampleValid` must be low after E4, high after E5 and low again after E6. The new phase values are read back only after E6.

// File: rtl/qws_pkg.sv
`timescale 1ns/1ps
package qws_pkg;

  // Strobes passed from the sequencer to the datapath
  typedef struct packed {
    logic issueEn;   // advance the selected voice and read its table
    logic capEn;     // memory data for the previous issue is on the bus
    logic capFirst;  // captured byte belongs to the first voice
    logic capLast;   // captured byte belongs to the last voice
  } qws_strobe_t;

endpackage

// File: rtl/qws_ctrl.sv
`timescale 1ns/1ps
module qws_ctrl
  import qws_pkg::*;
#(
  parameter int unsigned VOICE_CNT = 4,
  localparam int unsigned VSEL_W = (VOICE_CNT > 1) ? $clog2(VOICE_CNT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              runMode,
  output qws_strobe_t       strobes,
  output logic [VSEL_W-1:0] issueVoice
);

  localparam logic [VSEL_W-1:0] LAST_SLOT = VSEL_W'(VOICE_CNT - 1);

  logic              busy;
  logic [VSEL_W-1:0] slot;
  logic              capValid;
  logic [VSEL_W-1:0] capSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      slot     <= '0;
      capValid <= 1'b0;
      capSlot  <= '0;
    end else begin
      capValid <= busy;
      capSlot  <= slot;
      if (!busy) begin
        if (tick && runMode) begin
          busy <= 1'b1;
          slot <= '0;
        end
      end else begin
        slot <= slot + 1'b1;
        if (slot == LAST_SLOT) busy <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.issueEn  = busy;
    strobes.capEn    = capValid;
    strobes.capFirst = (capSlot == '0);
    strobes.capLast  = (capSlot == LAST_SLOT);
    issueVoice       = slot;
  end

  // R6: reads walk the voices in ascending order, one per cycle
  p_issue_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && slot != LAST_SLOT) |=> (busy && slot == $past(slot) + 1'b1));

  // R6: after the last voice is read, there is a gap of at least one cycle
  p_issue_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && slot == LAST_SLOT) |=> !busy);

  // R6: a sequence always starts at voice 0
  p_start_voice0_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (slot == '0));

  // R8: no sequence starts unless the run mode is selected
  p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !runMode) |=> !busy);

endmodule

// File: rtl/qws_datapath.sv
`timescale 1ns/1ps
module qws_datapath
  import qws_pkg::*;
#(
  parameter int unsigned VOICE_CNT  = 4,
  parameter int unsigned PHASE_W    = 32,
  parameter int unsigned FRAC_W     = 15,
  parameter int unsigned TABLE_AW   = 9,
  parameter int unsigned SAMPLE_W   = 8,
  parameter int unsigned REG_AW     = 6,
  parameter int unsigned MODE_W     = 2,
  parameter int unsigned MODE_ADDR  = 1,
  parameter int unsigned VOICE_BASE = 16,
  parameter int unsigned RUN_CODE   = 2,
  localparam int unsigned VSEL_W     = (VOICE_CNT > 1) ? $clog2(VOICE_CNT) : 1,
  localparam int unsigned DATA_W     = 8,
  localparam int unsigned REG_BYTES  = PHASE_W / DATA_W,
  localparam int unsigned BYTE_IDX_W = $clog2(REG_BYTES),
  localparam int unsigned LANE_W     = $clog2(PHASE_W),
  localparam int unsigned MIX_SHIFT  = $clog2(VOICE_CNT),
  localparam int unsigned ACC_W      = SAMPLE_W + MIX_SHIFT,
  localparam int unsigned MEM_AW     = TABLE_AW + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic                runMode,
  input  qws_strobe_t         strobes,
  input  logic [VSEL_W-1:0]   issueVoice,
  output logic [MEM_AW-1:0]   memRdAddr,
  input  logic [SAMPLE_W-1:0] memRdData,
  output logic [SAMPLE_W-1:0] mixOut,
  output logic                mixValid
);

  localparam logic [VSEL_W-1:0] LAST_VOICE = VSEL_W'(VOICE_CNT - 1);

  // Address decode, shared by reads and writes
  logic [REG_AW-1:0]     relAddr;
  logic                  inVoiceSpace;
  logic                  relIsInc;
  logic [VSEL_W-1:0]     relVoice;
  logic [BYTE_IDX_W-1:0] relByte;
  logic [LANE_W-1:0]     laneLo;
  logic                  wrVoiceSpace;
  logic                  wrMode;

  always_comb begin
    relAddr      = regAddr - REG_AW'(VOICE_BASE);
    inVoiceSpace = (regAddr >= REG_AW'(VOICE_BASE)) &&
                   (relAddr < REG_AW'(2 * REG_BYTES * VOICE_CNT));
    relByte      = relAddr[BYTE_IDX_W-1:0];
    relIsInc     = relAddr[BYTE_IDX_W];
    relVoice     = relAddr[BYTE_IDX_W+1 +: VSEL_W];
    laneLo       = LANE_W'((REG_BYTES - 1 - int'(relByte)) * DATA_W);
    wrVoiceSpace = regWrEn && inVoiceSpace;
    wrMode       = regWrEn && (regAddr == REG_AW'(MODE_ADDR));
  end

  // Mode register
  logic [MODE_W-1:0] modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       modeQ <= '0;
    else if (wrMode) modeQ <= regWrData[MODE_W-1:0];
  end

  assign runMode = (modeQ == MODE_W'(RUN_CODE));

  // Voice registers, with a single shared adder for the issued voice
  logic [PHASE_W-1:0] phaseAll [VOICE_CNT];
  logic [PHASE_W-1:0] incAll   [VOICE_CNT];
  logic [PHASE_W-1:0] nextPhase;

  assign nextPhase = phaseAll[issueVoice] + incAll[issueVoice];

  for (genvar v = 0; v < VOICE_CNT; v++) begin : g_voice
    logic [PHASE_W-1:0] phR;
    logic [PHASE_W-1:0] incR;
    logic               advHere;
    logic               wrHere;

    assign advHere = strobes.issueEn && (issueVoice == VSEL_W'(v));
    assign wrHere  = wrVoiceSpace && (relVoice == VSEL_W'(v));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        phR  <= '0;
        incR <= '0;
      end else begin
        // a host byte write to the phase wins over the sequencer advance
        if (wrHere && !relIsInc)  phR[laneLo +: DATA_W] <= regWrData;
        else if (advHere)         phR <= nextPhase;
        if (wrHere && relIsInc)   incR[laneLo +: DATA_W] <= regWrData;
      end
    end

    assign phaseAll[v] = phR;
    assign incAll[v]   = incR;
  end

  // Register read mux
  logic [PHASE_W-1:0] rdWord;

  always_comb begin
    rdWord    = relIsInc ? incAll[relVoice] : phaseAll[relVoice];
    regRdData = '0;
    if (regAddr == REG_AW'(MODE_ADDR)) regRdData = DATA_W'(modeQ);
    else if (inVoiceSpace)             regRdData = rdWord[laneLo +: DATA_W];
  end

  // Table address: the top voice-index bit picks the bank, updated phase bits give the offset
  assign memRdAddr = {issueVoice[VSEL_W-1], nextPhase[FRAC_W +: TABLE_AW]};

  // Mixer
  logic [ACC_W-1:0]    accQ;
  logic [ACC_W-1:0]    sampleExt;
  logic [ACC_W-1:0]    accNext;
  logic [SAMPLE_W-1:0] mixQ;
  logic                validQ;

  assign sampleExt = ACC_W'(memRdData);
  assign accNext   = accQ + sampleExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      mixQ   <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobes.capEn && strobes.capLast;
      if (strobes.capEn) begin
        accQ <= strobes.capFirst ? sampleExt : accNext;
        if (strobes.capLast) mixQ <= accNext[MIX_SHIFT +: SAMPLE_W];
      end
    end
  end

  assign mixOut   = mixQ;
  assign mixValid = validQ;

  // R7: the valid strobe lasts a single cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    mixValid |=> !mixValid);

  // R7: a result follows the last voice's read by two cycles
  p_valid_after_last_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    mixValid |-> ($past(strobes.issueEn, 2) && $past(issueVoice, 2) == LAST_VOICE));

  // R7: the output byte holds between results
  p_mix_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    !mixValid |-> $stable(mixQ));

  // R3: the upper bits of the mode byte always read back as zero
  p_mode_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_AW'(MODE_ADDR)) |-> (regRdData[DATA_W-1:MODE_W] == '0));

endmodule

// File: rtl/quad_wave_synth.sv
`timescale 1ns/1ps
module quad_wave_synth
  import qws_pkg::*;
#(
  parameter int unsigned VOICE_CNT = 4,
  parameter int unsigned PHASE_W   = 32,
  parameter int unsigned FRAC_W    = 15,
  parameter int unsigned TABLE_AW  = 9,
  parameter int unsigned SAMPLE_W  = 8,
  parameter int unsigned REG_AW    = 6,
  localparam int unsigned VSEL_W   = (VOICE_CNT > 1) ? $clog2(VOICE_CNT) : 1,
  localparam int unsigned MEM_AW   = TABLE_AW + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  output logic                memRdEn,
  output logic [MEM_AW-1:0]   memRdAddr,
  input  logic [SAMPLE_W-1:0] memRdData,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                sampleValid
);

  qws_strobe_t         strobes;
  logic [VSEL_W-1:0]   issueVoice;
  logic                runMode;
  logic [SAMPLE_W-1:0] mixOut;
  logic                mixValid;

  qws_ctrl #(
    .VOICE_CNT(VOICE_CNT)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .runMode   (runMode),
    .strobes   (strobes),
    .issueVoice(issueVoice)
  );

  qws_datapath #(
    .VOICE_CNT(VOICE_CNT),
    .PHASE_W  (PHASE_W),
    .FRAC_W   (FRAC_W),
    .TABLE_AW (TABLE_AW),
    .SAMPLE_W (SAMPLE_W),
    .REG_AW   (REG_AW)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .runMode   (runMode),
    .strobes   (strobes),
    .issueVoice(issueVoice),
    .memRdAddr (memRdAddr),
    .memRdData (memRdData),
    .mixOut    (mixOut),
    .mixValid  (mixValid)
  );

  assign memRdEn     = strobes.issueEn;
  assign leftOut     = mixOut;
  assign rightOut    = mixOut;
  assign sampleValid = mixValid;

endmodule

// File: tb/quad_wave_synth_tb_top.sv
`timescale 1ns/1ps
module quad_wave_synth_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [5:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       memRdEn;
  logic [9:0] memRdAddr;
  logic [7:0] memRdData;
  logic [7:0] leftOut, rightOut;
  logic       sampleValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_wave_synth dut_i (
    .clk(clk), .rstN(rstN), .tick(tick),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid)
  );

  // Sample memory model: one-cycle read latency
  logic [7:0] mem [1024];
  logic [7:0] memQ = '0;
  assign memRdData = memQ;

  int        cycleCnt = 0;
  int        logCnt = 0;
  int        validCnt = 0;
  logic [9:0] logAddr [256];
  int        logCyc  [256];

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (memRdEn) begin
      memQ <= mem[memRdAddr];
      if (logCnt < 256) begin
        logAddr[logCnt] <= memRdAddr;
        logCyc[logCnt]  <= cycleCnt;
      end
      logCnt <= logCnt + 1;
    end
    if (sampleValid) validCnt <= validCnt + 1;
  end

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] shPh  [4];
  logic [31:0] shInc [4];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrByte(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdByte(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic wrWord(input logic [5:0] a, input logic [31:0] w);
    for (int i = 0; i < 4; i++) wrByte(a + 6'(i), w[(3-i)*8 +: 8]);
  endtask

  task automatic rdWord(input logic [5:0] a, output logic [31:0] w);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rdByte(a + 6'(i), b);
      w[(3-i)*8 +: 8] = b;
    end
  endtask

  task automatic setVoice(input int v, input logic [31:0] ph, input logic [31:0] inc);
    wrWord(6'(16 + 8*v), ph);
    wrWord(6'(20 + 8*v), inc);
    shPh[v] = ph;
    shInc[v] = inc;
  endtask

  task automatic checkPhases(input string req);
    logic [31:0] w;
    for (int v = 0; v < 4; v++) begin
      rdWord(6'(16 + 8*v), w);
      chk(req, w, shPh[v]);
    end
  endtask

  // One accepted tick; tick held high for 1+hold edges
  task automatic runTick(input int hold);
    logic [9:0] expAddr [4];
    int sum;
    int base, c0, vBase;
    logic [7:0] expMix;
    sum = 0;
    for (int v = 0; v < 4; v++) begin
      shPh[v] = shPh[v] + shInc[v];
      expAddr[v] = {(v >= 2) ? 1'b1 : 1'b0, shPh[v][23:15]};
      sum += int'(mem[expAddr[v]]);
    end
    expMix = 8'(sum >> 2);
    @(negedge clk);
    base = logCnt; c0 = cycleCnt; vBase = validCnt;
    tick = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= hold) tick = 1'b0;
      if (i == 4) chk("R7 valid low after E4", 32'(sampleValid), 32'd0);
      if (i == 5) begin
        chk("R7 valid after E5", 32'(sampleValid), 32'd1);
        chk("R7 left mix", 32'(leftOut), 32'(expMix));
        chk("R7 right mix", 32'(rightOut), 32'(expMix));
      end
    end
    @(negedge clk);
    chk("R7 valid single cycle", 32'(sampleValid), 32'd0);
    chk("R7 output held", 32'(leftOut), 32'(expMix));
    chk("R6 read count", 32'(logCnt - base), 32'd4);
    chk("R9 one result", 32'(validCnt - vBase), 32'd1);
    for (int k = 0; k < 4; k++) begin
      chk("R5 read address", 32'(logAddr[base + k]), 32'(expAddr[k]));
      chk("R6 read cycle", 32'(logCyc[base + k]), 32'(c0 + 1 + k));
    end
    checkPhases("R4 phase advanced");
  endtask

  // Tick while not in run mode
  task automatic idleTick(input logic [1:0] mode);
    int base, vBase;
    wrByte(6'h01, {6'b0, mode});
    @(negedge clk);
    base = logCnt; vBase = validCnt;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 no reads", 32'(logCnt - base), 32'd0);
    chk("R8 no valid", 32'(validCnt - vBase), 32'd0);
    checkPhases("R8 phase unchanged");
  endtask

  task automatic t_reset;
    logic [31:0] w;
    logic [7:0] b;
    chk("R1 valid", 32'(sampleValid), 32'd0);
    chk("R1 left", 32'(leftOut), 32'd0);
    chk("R1 right", 32'(rightOut), 32'd0);
    rdByte(6'h01, b);
    chk("R1 mode", 32'(b), 32'd0);
    for (int v = 0; v < 4; v++) begin
      rdWord(6'(16 + 8*v), w); chk("R1 phase", w, 32'd0);
      rdWord(6'(20 + 8*v), w); chk("R1 incr", w, 32'd0);
    end
  endtask

  task automatic t_regs;
    logic [7:0] b;
    setVoice(1, 32'h1234_5678, 32'hA5C3_0F1E);
    rdByte(6'h18, b); chk("R2 big-endian msb", 32'(b), 32'h12);
    rdByte(6'h1B, b); chk("R2 big-endian lsb", 32'(b), 32'h78);
    rdByte(6'h1C, b); chk("R2 incr msb", 32'(b), 32'hA5);
    setVoice(0, 32'hDEAD_BEEF, 32'h0102_0304);
    setVoice(2, 32'h0000_0001, 32'hFFFF_FFFF);
    setVoice(3, 32'h8000_0000, 32'h0000_8000);
    checkPhases("R2 phase readback");
    for (int v = 0; v < 4; v++) begin
      logic [31:0] w;
      rdWord(6'(20 + 8*v), w);
      chk("R2 incr readback", w, shInc[v]);
    end
    wrByte(6'h01, 8'hFF);
    rdByte(6'h01, b); chk("R3 mode two bits", 32'(b), 32'h03);
    wrByte(6'h01, 8'hFE);
    rdByte(6'h01, b); chk("R3 mode value", 32'(b), 32'h02);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 73) + 5);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    t_reset();                           // R1
    t_regs();                            // R2, R3
    idleTick(2'd0);                      // R8 mode 0
    idleTick(2'd1);                      // R8 mode 1
    idleTick(2'd3);                      // R8 mode 3

    // R4 R5 R6 R7: distinct phases and increments, two ticks in a row
    wrByte(6'h01, 8'h02);
    setVoice(0, 32'h0000_0000, 32'h0001_8000);
    setVoice(1, 32'h0010_0000, 32'h0000_4000);
    setVoice(2, 32'h1234_5678, 32'h00AB_CDEF);
    setVoice(3, 32'h00FF_8000, 32'h0001_0000);
    runTick(0);
    runTick(0);

    // R7: extremes of the average, full scale and truncation
    for (int v = 0; v < 4; v++) setVoice(v, 32'h0, 32'h0);
    mem[0] = 8'hFF; mem[10'h200] = 8'hFF;
    runTick(0);
    mem[0] = 8'h01; mem[10'h200] = 8'h02;
    runTick(0);

    // R10: carries into the upper byte, which does not reach the address
    setVoice(0, 32'h00FF_FFFF, 32'h0000_0001);
    setVoice(1, 32'h7F7F_FFFF, 32'h0000_0001);
    setVoice(2, 32'hAB7F_FFFF, 32'h0000_8000);
    setVoice(3, 32'hFFFF_FFFF, 32'h0000_0002);
    runTick(0);

    // R9: tick held high through the whole sequence
    setVoice(0, 32'h0003_0000, 32'h0002_0000);
    setVoice(1, 32'h0100_0000, 32'h0040_0000);
    setVoice(2, 32'h0000_0000, 32'h00FF_8000);
    setVoice(3, 32'h0055_5555, 32'h0011_1111);
    runTick(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule